// File: doc/BRIEF.md
# Multiplexed LCD Frame Scan Sequencer

This block sequences row and column drive timing for a passive dot-matrix panel of 40 rows by 101 columns at a 1:40 multiplex ratio. It runs from the display oscillator. Each frame lasts exactly 3072 oscillator cycles and is split into 40 row slots. A fractional accumulator sets the slot boundaries, so every slot lasts 76 or 77 cycles. While a row is active, the block addresses display memory by bank and bit position and receives one line of 101 pixel bits. It then turns each pixel into a column drive-level code. A one-hot row select, a frame polarity flag and a drive-level code for every row output are produced alongside the column codes.

Two mode bits override or reinterpret the memory data: blank, all on, normal video or inverse video. Drive levels leave the block as 3-bit codes only. The analog side turns each code into a voltage. Power-down freezes the scan and parks every output at the supply code. A synchronous reset takes two further clock cycles to complete after it is released. Command writes made during that time are discarded.

Top module: `lcd_scan_sequencer`

## Requirements
- R1: After the reset completes, let t count the clock edges taken with power-down low. The active row is floor((t mod 3072) * 40 / 3072), so every frame is exactly 3072 cycles. `row_sel` is one-hot with bit r marking row r.
- R2: `frame_pol` is 0 after reset and inverts exactly when the active row wraps from 39 back to 0.
- R3: Row level codes are VDD=0, V2=1, V3=2, V4=3, V5=4, VLCD=5. The active row gets 0 when polarity is 0 and 5 when polarity is 1. Every other row gets 4 when polarity is 0 and 1 when polarity is 1.
- R4: Mode code {E,D} is applied by a one-cycle `cmd_we`. Code 2'b10 displays the memory bit as is, and code 2'b11 displays its complement. A lit pixel's column gets 5 when polarity is 0 and 0 when polarity is 1. An unlit pixel's column gets 3 when polarity is 0 and 2 when polarity is 1. Column c uses bit c of `line_data`.
- R5: Mode 2'b00 shows every pixel unlit and mode 2'b01 shows every pixel lit, whatever the memory holds.
- R6: The memory address for row r is bank r/8 on `rd_bank` and bit position r%8 on `rd_bit`.
- R7: While `pwr_down` is 1, every row and column code is 0 and `row_sel` is all zero. The row, the slot phase and the polarity hold, and scanning resumes from the same point when `pwr_down` falls. Command writes are still accepted.
- R8: While `rst` is high and for the two clock edges after it falls, `cmd_we` is ignored and the scan stays at row 0 with polarity 0. The mode resets to blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display oscillator clock |
| rst | input | 1 | Synchronous reset request, active high |
| pwr_down | input | 1 | Power-down: freeze scan, drive supply code |
| cmd_we | input | 1 | Command write strobe for the mode bits |
| cmd_mode | input | 2 | Mode {E,D}: 00 blank, 01 all on, 10 normal, 11 inverse |
| rd_bank | output | 3 | Memory bank of the active row |
| rd_bit | output | 3 | Bit position inside each column byte for the active row |
| line_data | input | 101 | Pixel bits of the addressed line, bit c for column c |
| row_sel | output | 40 | One-hot active row |
| frame_pol | output | 1 | Frame polarity flag |
| row_lvl | output | 120 | 3-bit level code per row, row r at bits 3r+2..3r |
| col_lvl | output | 303 | 3-bit level code per column, column c at bits 3c+2..3c |

## Verification
The assertions assume that `rst` is held high for at least two clock edges, so the state sampled in the past is already defined when checking begins. They also assume that `line_data` settles combinationally from `rd_bank` and `rd_bit` within the same cycle. The bench meets both conditions: it holds reset for three edges, it models the memory as a pure function of bank, column and bit, and it changes inputs only on falling edges. The bench holds power-down for whole cycles and writes commands both while the reset is finishing and during power-down, so that the discard and accept rules are exercised.

// File: rtl/lcd_scan_sequencer.sv
module lcd_scan_sequencer #(
  parameter int ROWS  = 40,
  parameter int COLS  = 101,
  parameter int FRAME = 3072
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pwr_down,
  input  logic                 cmd_we,
  input  logic [1:0]           cmd_mode,
  output logic [2:0]           rd_bank,
  output logic [2:0]           rd_bit,
  input  logic [COLS-1:0]      line_data,
  output logic [ROWS-1:0]      row_sel,
  output logic                 frame_pol,
  output logic [3*ROWS-1:0]    row_lvl,
  output logic [3*COLS-1:0]    col_lvl
);

  localparam int RW       = $clog2(ROWS);
  localparam int AW       = $clog2(FRAME + ROWS + 1);
  localparam int SLOT_MIN = FRAME / ROWS;
  localparam int SLOT_MAX = SLOT_MIN + ((FRAME % ROWS) != 0 ? 1 : 0);

  localparam logic [2:0] LV_VDD  = 3'd0;
  localparam logic [2:0] LV_V2   = 3'd1;
  localparam logic [2:0] LV_V3   = 3'd2;
  localparam logic [2:0] LV_V4   = 3'd3;
  localparam logic [2:0] LV_V5   = 3'd4;
  localparam logic [2:0] LV_VLCD = 3'd5;

  logic [1:0]    rst_cnt;
  logic [RW-1:0] row_q;
  logic [AW-1:0] acc_q;
  logic          pol_q;
  logic [1:0]    mode_q;

  wire          ready    = (rst_cnt == 2'd2);
  wire          scan_en  = ready && !pwr_down;
  wire [AW-1:0] acc_sum  = acc_q + AW'(ROWS);
  wire          advance  = (acc_sum >= AW'(FRAME));
  wire          last_row = (row_q == RW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_cnt <= 2'd0;
      row_q   <= '0;
      acc_q   <= '0;
      pol_q   <= 1'b0;
      mode_q  <= 2'b00;
    end else begin
      if (!ready) rst_cnt <= rst_cnt + 2'd1;
      if (ready && cmd_we) mode_q <= cmd_mode;
      if (scan_en) begin
        acc_q <= advance ? acc_sum - AW'(FRAME) : acc_sum;
        if (advance) begin
          row_q <= last_row ? '0 : row_q + RW'(1);
          if (last_row) pol_q <= ~pol_q;
        end
      end
    end
  end

  assign rd_bank   = 3'(row_q >> 3);
  assign rd_bit    = row_q[2:0];
  assign frame_pol = pol_q;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    wire active = ready && (row_q == RW'(r));
    assign row_sel[r] = active && !pwr_down;
    assign row_lvl[3*r +: 3] = pwr_down ? LV_VDD :
                               active   ? (pol_q ? LV_VLCD : LV_VDD) :
                                          (pol_q ? LV_V2   : LV_V5);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    wire lit = mode_q[1] ? (line_data[c] ^ mode_q[0]) : mode_q[0];
    assign col_lvl[3*c +: 3] = pwr_down ? LV_VDD :
                               lit      ? (pol_q ? LV_VDD : LV_VLCD) :
                                          (pol_q ? LV_V3  : LV_V4);
  end

  logic [AW-1:0] slot_cnt;
  logic [RW-1:0] row_next;
  assign row_next = !(scan_en && advance) ? row_q : (last_row ? '0 : row_q + RW'(1));

  always_ff @(posedge clk) begin
    if (rst) slot_cnt <= '0;
    else if (row_next != row_q) slot_cnt <= '0;
    else if (scan_en) slot_cnt <= slot_cnt + AW'(1);
  end

  assert_row_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(row_sel));

  assert_slot_len_R1: assert property (@(posedge clk) disable iff (rst)
    (row_next != row_q) |-> (slot_cnt >= AW'(SLOT_MIN - 1) && slot_cnt <= AW'(SLOT_MAX - 1)));

  assert_pol_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (frame_pol != $past(frame_pol)) |-> (row_q == '0 && $past(row_q) == RW'(ROWS - 1)));

  assert_pd_outputs_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> (row_sel == '0 && row_lvl == '0 && col_lvl == '0));

  assert_pd_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> ($stable(row_q) && $stable(acc_q) && $stable(frame_pol)));

  assert_busy_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    (!ready && cmd_we) |=> (mode_q == $past(mode_q)));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ready |=> (row_q == '0 && frame_pol == 1'b0));

endmodule

// File: tb/test_lcd_scan_sequencer.sv
`timescale 1ns/1ps
module test_lcd_scan_sequencer;
  localparam int ROWS = 40, COLS = 101, FRAME = 3072;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, pwr_down = 1'b0, cmd_we = 1'b0;
  logic [1:0] cmd_mode = 2'b00;
  logic [2:0] rd_bank, rd_bit;
  logic [COLS-1:0] line_data;
  logic [ROWS-1:0] row_sel;
  logic frame_pol;
  logic [3*ROWS-1:0] row_lvl;
  logic [3*COLS-1:0] col_lvl;

  lcd_scan_sequencer i_lcd_scan_sequencer (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .cmd_we(cmd_we), .cmd_mode(cmd_mode),
    .rd_bank(rd_bank), .rd_bit(rd_bit), .line_data(line_data), .row_sel(row_sel),
    .frame_pol(frame_pol), .row_lvl(row_lvl), .col_lvl(col_lvl));

  function automatic logic pix(int bank, int col, int bitp);
    return ((bank * 13 + col * 7 + bitp * 5) % 3) == 0;
  endfunction

  always_comb
    for (int c = 0; c < COLS; c++) line_data[c] = pix(int'(rd_bank), c, int'(rd_bit));

  int checks = 0, errors = 0;
  int t = 0, rc = 0;
  logic [1:0] em = 2'b00;
  bit done = 0;

  task automatic cmp(string tag, logic [511:0] act, logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin rc = 0; t = 0; em = 2'b00; end
    else begin
      if (rc == 2 && !pwr_down) t++;
      if (rc == 2 && cmd_we) em = cmd_mode;
      if (rc < 2) rc++;
    end
    @(negedge clk);
  endtask

  task automatic check_all();
    int row, pol;
    logic [ROWS-1:0] es;
    logic [3*ROWS-1:0] erl;
    logic [3*COLS-1:0] ecl;
    row = ((t % FRAME) * ROWS) / FRAME;
    pol = (t / FRAME) % 2;
    es = '0; erl = '0; ecl = '0;
    if (!pwr_down) begin
      es[row] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        erl[3*r +: 3] = (r == row) ? (pol ? 3'd5 : 3'd0) : (pol ? 3'd1 : 3'd4);
      for (int c = 0; c < COLS; c++) begin
        logic b, lit;
        b = pix(row / 8, c, row % 8);
        case (em)
          2'b00: lit = 1'b0;
          2'b01: lit = 1'b1;
          2'b10: lit = b;
          default: lit = ~b;
        endcase
        ecl[3*c +: 3] = lit ? (pol ? 3'd0 : 3'd5) : (pol ? 3'd2 : 3'd3);
      end
    end
    cmp(pwr_down ? "R7 row_sel" : "R1 row_sel", 512'(row_sel), 512'(es));
    cmp("R2 frame_pol", 512'(frame_pol), 512'(pol));
    cmp("R6 rd_bank", 512'(rd_bank), 512'(row / 8));
    cmp("R6 rd_bit", 512'(rd_bit), 512'(row % 8));
    cmp(pwr_down ? "R7 row_lvl" : "R3 row_lvl", 512'(row_lvl), 512'(erl));
    cmp(pwr_down ? "R7 col_lvl" : (em[1] ? "R4 col_lvl" : "R5 col_lvl"), 512'(col_lvl), 512'(ecl));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin tick(); check_all(); end
  endtask

  task automatic set_mode(logic [1:0] m);
    cmd_mode = m; cmd_we = 1'b1; tick(); cmd_we = 1'b0; check_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cmd_we = 1'b1; cmd_mode = 2'b10;
    repeat (3) tick();
    rst = 1'b0;
    tick(); tick();
    cmd_we = 1'b0;
    // R8: writes during reset ignored, scan at row 0, blank columns
    cmp("R8 row_sel after reset", 512'(row_sel), 512'(1));
    cmp("R8 pol after reset", 512'(frame_pol), 512'(0));
    cmp("R8 blank after ignored write", 512'(col_lvl), 512'({COLS{3'd3}}));
    check_all();
    set_mode(2'b10);
    run(FRAME + 300);
    set_mode(2'b11);
    run(400);
    set_mode(2'b01);
    run(200);
    set_mode(2'b00);
    run(200);
    pwr_down = 1'b1;
    run(50);
    set_mode(2'b10);
    run(50);
    pwr_down = 1'b0;
    run(FRAME);
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    cmd_we = 1'b1; cmd_mode = 2'b01;
    tick(); tick();
    cmd_we = 1'b0;
    cmp("R8 row_sel after mid-scan reset", 512'(row_sel), 512'(1));
    cmp("R8 pol after mid-scan reset", 512'(frame_pol), 512'(0));
    cmp("R8 mode blank after mid-scan reset", 512'(col_lvl), 512'({COLS{3'd3}}));
    run(100);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule